// File: doc/BRIEF.md
# Two-Step Resonance Sweep Tracker

This block searches for the drive frequency at which an ultrasonic transducer draws the most current, then holds that frequency for a while. It reads an 8-bit parallel ADC through an active-low chip-select, write-start and read-enable handshake. The ADC reports end of conversion on an active-low interrupt line. It adds up a window of samples at each candidate frequency and keeps the candidate with the largest sum. Frequencies are expressed as PWM period counts at the system clock, so a smaller count means a higher frequency. Each new period is handed to the PWM generator, which lies outside this block, together with a one-cycle valid strobe.

A recapture pass has two sweeps. The coarse sweep runs from the shortest period (highest frequency) to the longest in large steps. The coarse winner is pulled inward if it sits too close to a band edge. A fine sweep then covers a narrow window centred on that point in small steps. The fine winner is then driven for a fixed number of cycles, and the block starts a new recapture pass. It keeps looping like this for as long as it is out of reset.

Top module: `reso_sweep_tracker`

## Requirements
- R1: While `rst_n` is low, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are 1 and `locked` and `drive_period_vld` are 0. On the first clock edge after reset, `drive_period` = P_MIN is issued with `drive_period_vld` = 1.
- R2: One conversion goes through these steps. `adc_cs_n` and `adc_wr_n` go low together for DIV cycles. Then `adc_wr_n` rises with `adc_cs_n` still low, and the block waits until it sees `adc_intr_n` = 0. Then `adc_rd_n` goes low for DIV cycles while the data is latched. Then `adc_rd_n` and `adc_cs_n` rise together. `adc_rd_n` and `adc_wr_n` are never low at the same time, and `adc_rd_n` is never low while `adc_cs_n` is high.
- R3: The figure of merit for a period is the sum of WINDOW samples latched after that period was issued. The partial sum is discarded whenever a new period is issued.
- R4: A sum replaces the stored maximum and the best period only if it is strictly greater, so on a tie the earlier (smaller) period wins. The maximum is cleared to 0 and the best period is set to the first point at the start of each sweep.
- R5: The coarse sweep issues P_MIN, P_MIN+COARSE_STEP, and so on, up to the last value that does not exceed P_MAX.
- R6: If the coarse best is below P_MIN+EDGE_MARGIN, it becomes P_MIN+EDGE_MARGIN. If it is above P_MAX-EDGE_MARGIN, it becomes P_MAX-EDGE_MARGIN.
- R7: The fine sweep issues c-EDGE_MARGIN, then steps of FINE_STEP, up to c+EDGE_MARGIN, where c is the clamped coarse best.
- R8: After the fine sweep, the fine best period is issued and `locked` is 1 for exactly RUN_LEN cycles. `drive_period` does not change during that time.
- R9: When the run ends, `locked` falls and P_MIN is issued again, which starts a new coarse sweep.
- R10: Every change of `drive_period` is accompanied by `drive_period_vld` = 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_intr_n | input | 1 | ADC conversion done, active low |
| adc_data | input | DW | ADC parallel data |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_wr_n | output | 1 | ADC conversion start, active low |
| adc_rd_n | output | 1 | ADC output enable, active low |
| drive_period | output | PW | PWM period count to drive |
| drive_period_vld | output | 1 | One-cycle strobe on each new period |
| locked | output | 1 | High during the run-at-resonance phase |

## Verification
The bench models the ADC with a random conversion delay. It also models a resonance curve whose peak moves between passes, and it checks every period issued in each pass against a model of the search. Directed peaks cover these cases:
- An exact tie between coarse points and between fine points. A design that lets later points win on a tie would lock one fine step too high.
- A peak at either band edge. Without the clamp, the fine window would leave the band.
- A peak far outside the band, so every sum is zero. If the maximum is not cleared, or the best period is not preset, the fine start or the lock point is wrong.

The handshake monitor flags these faults:
- A read that begins before the interrupt line goes low.
- Read and write strobes that overlap.
- A strobe that is not exactly DIV cycles wide.

// File: rtl/reso_pkg.sv
package reso_pkg;
    typedef enum logic [1:0] {
        ADC_IDLE,
        ADC_CONV,
        ADC_WAIT,
        ADC_READ
    } adc_st_t;

    typedef enum logic [2:0] {
        SW_INIT,
        SW_COARSE,
        SW_CEND,
        SW_FINE,
        SW_FEND,
        SW_RUN
    } sw_st_t;
endpackage

// File: rtl/reso_adc_seq.sv
module reso_adc_seq
    import reso_pkg::*;
#(
    parameter int DIV = 2,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          intr_n,
    input  logic [DW-1:0] data_in,
    output logic          cs_n,
    output logic          wr_n,
    output logic          rd_n,
    output logic [DW-1:0] smp,
    output logic          smp_vld
);
    localparam int CW = $clog2(DIV + 1);

    typedef struct packed {
        adc_st_t       st;
        logic [CW-1:0] cnt;
        logic          cs_n;
        logic          wr_n;
        logic          rd_n;
        logic [DW-1:0] smp;
        logic          vld;
    } seq_t;

    seq_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        d.vld = 1'b0;
        tick = (q.cnt == '0);
        d.cnt = tick ? CW'(DIV - 1) : q.cnt - 1'b1;
        unique case (q.st)
            ADC_IDLE: if (tick) d.st = ADC_CONV;
            ADC_CONV: if (tick) d.st = ADC_WAIT;
            ADC_WAIT: if (tick && !intr_n) d.st = ADC_READ;
            ADC_READ: if (tick) begin
                d.smp = data_in;
                d.vld = 1'b1;
                d.st  = ADC_IDLE;
            end
            default:  d.st = ADC_IDLE;
        endcase
        d.cs_n = (d.st == ADC_IDLE);
        d.wr_n = (d.st != ADC_CONV);
        d.rd_n = (d.st != ADC_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ADC_IDLE;
            q.cnt  <= CW'(DIV - 1);
            q.cs_n <= 1'b1;
            q.wr_n <= 1'b1;
            q.rd_n <= 1'b1;
            q.smp  <= '0;
            q.vld  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cs_n    = q.cs_n;
    assign wr_n    = q.wr_n;
    assign rd_n    = q.rd_n;
    assign smp     = q.smp;
    assign smp_vld = q.vld;

    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    assert_rd_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);
    assert_rd_after_intr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(intr_n));
endmodule

// File: rtl/reso_accum.sv
module reso_accum #(
    parameter int DW     = 8,
    parameter int WINDOW = 4,
    parameter int SW     = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] smp,
    input  logic          smp_vld,
    output logic [SW-1:0] sum,
    output logic          sum_vld
);
    localparam int NW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic [SW-1:0] acc;
        logic [SW-1:0] res;
        logic          vld;
    } acc_t;

    acc_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (clr) begin
            d.cnt = '0;
            d.acc = '0;
        end else if (smp_vld) begin
            if (q.cnt == NW'(WINDOW - 1)) begin
                d.res = q.acc + SW'(smp);
                d.vld = 1'b1;
                d.cnt = '0;
                d.acc = '0;
            end else begin
                d.acc = q.acc + SW'(smp);
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sum     = q.res;
    assign sum_vld = q.vld;

    assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < NW'(WINDOW));
    assert_clear_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0) && !sum_vld);
endmodule

// File: rtl/reso_peak.sv
module reso_peak #(
    parameter int SW = 11,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [PW-1:0] start_period,
    input  logic          sum_vld,
    input  logic [SW-1:0] sum,
    input  logic [PW-1:0] period,
    output logic [PW-1:0] best
);
    typedef struct packed {
        logic [SW-1:0] max;
        logic [PW-1:0] best;
    } pk_t;

    pk_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.max  = '0;
            d.best = start_period;
        end else if (sum_vld && (sum > q.max)) begin
            d.max  = sum;
            d.best = period;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign best = q.best;

    assert_max_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_vld && !clr) |=> (q.max >= $past(q.max)));
    assert_tie_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_vld && !clr && (sum <= q.max)) |=> $stable(best));
endmodule

// File: rtl/reso_sweep_tracker.sv
module reso_sweep_tracker
    import reso_pkg::*;
#(
    parameter int PW          = 16,
    parameter int DW          = 8,
    parameter int DIV         = 32,
    parameter int WINDOW      = 16,
    parameter int P_MIN       = 1000,
    parameter int P_MAX       = 1100,
    parameter int COARSE_STEP = 10,
    parameter int FINE_STEP   = 1,
    parameter int EDGE_MARGIN = 20,
    parameter int RUN_LEN     = 50000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adc_intr_n,
    input  logic [DW-1:0] adc_data,
    output logic          adc_cs_n,
    output logic          adc_wr_n,
    output logic          adc_rd_n,
    output logic [PW-1:0] drive_period,
    output logic          drive_period_vld,
    output logic          locked
);
    localparam int SW = DW + $clog2(WINDOW + 1);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [PW-1:0] LO_EDGE = PW'(P_MIN + EDGE_MARGIN);
    localparam logic [PW-1:0] HI_EDGE = PW'(P_MAX - EDGE_MARGIN);

    typedef struct packed {
        sw_st_t        st;
        logic [PW-1:0] period;
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
        logic [RW-1:0] run_cnt;
        logic          vld;
    } trk_t;

    trk_t q, d;
    logic          acc_clr, pk_clr;
    logic [PW-1:0] pk_start, best, centre;
    logic [DW-1:0] smp;
    logic          smp_vld, sum_vld;
    logic [SW-1:0] sum;

    reso_adc_seq #(.DIV(DIV), .DW(DW)) u_seq (
        .clk, .rst_n, .intr_n(adc_intr_n), .data_in(adc_data),
        .cs_n(adc_cs_n), .wr_n(adc_wr_n), .rd_n(adc_rd_n),
        .smp, .smp_vld
    );

    reso_accum #(.DW(DW), .WINDOW(WINDOW), .SW(SW)) u_acc (
        .clk, .rst_n, .clr(acc_clr), .smp, .smp_vld, .sum, .sum_vld
    );

    reso_peak #(.SW(SW), .PW(PW)) u_peak (
        .clk, .rst_n, .clr(pk_clr), .start_period(pk_start),
        .sum_vld, .sum, .period(q.period), .best
    );

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        acc_clr  = 1'b0;
        pk_clr   = 1'b0;
        pk_start = PW'(P_MIN);
        centre   = (best < LO_EDGE) ? LO_EDGE :
                   (best > HI_EDGE) ? HI_EDGE : best;
        unique case (q.st)
            SW_INIT: begin
                d.st     = SW_COARSE;
                d.period = PW'(P_MIN);
                d.vld    = 1'b1;
                acc_clr  = 1'b1;
                pk_clr   = 1'b1;
            end
            SW_COARSE: if (sum_vld) begin
                if (({1'b0, q.period} + (PW+1)'(COARSE_STEP)) > (PW+1)'(P_MAX)) begin
                    d.st = SW_CEND;
                end else begin
                    d.period = q.period + PW'(COARSE_STEP);
                    d.vld    = 1'b1;
                    acc_clr  = 1'b1;
                end
            end
            SW_CEND: begin
                d.lo     = centre - PW'(EDGE_MARGIN);
                d.hi     = centre + PW'(EDGE_MARGIN);
                d.period = centre - PW'(EDGE_MARGIN);
                d.vld    = 1'b1;
                d.st     = SW_FINE;
                acc_clr  = 1'b1;
                pk_clr   = 1'b1;
                pk_start = centre - PW'(EDGE_MARGIN);
            end
            SW_FINE: if (sum_vld) begin
                if (({1'b0, q.period} + (PW+1)'(FINE_STEP)) > {1'b0, q.hi}) begin
                    d.st = SW_FEND;
                end else begin
                    d.period = q.period + PW'(FINE_STEP);
                    d.vld    = 1'b1;
                    acc_clr  = 1'b1;
                end
            end
            SW_FEND: begin
                d.period  = best;
                d.vld     = 1'b1;
                d.run_cnt = RW'(RUN_LEN - 1);
                d.st      = SW_RUN;
            end
            SW_RUN: begin
                if (q.run_cnt == '0) begin
                    d.st     = SW_COARSE;
                    d.period = PW'(P_MIN);
                    d.vld    = 1'b1;
                    acc_clr  = 1'b1;
                    pk_clr   = 1'b1;
                end else begin
                    d.run_cnt = q.run_cnt - 1'b1;
                end
            end
            default: d.st = SW_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= SW_INIT;
            q.period  <= PW'(P_MIN);
            q.lo      <= PW'(P_MIN);
            q.hi      <= PW'(P_MAX);
            q.run_cnt <= '0;
            q.vld     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign drive_period     = q.period;
    assign drive_period_vld = q.vld;
    assign locked           = (q.st == SW_RUN);

    assert_period_in_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_period >= PW'(P_MIN)) && (drive_period <= PW'(P_MAX)));
    assert_fine_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_FINE) |-> (drive_period >= q.lo) && (drive_period <= q.hi)
                              && ((q.hi - q.lo) == PW'(2 * EDGE_MARGIN)));
    assert_fine_centre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_FINE) |-> (q.lo >= PW'(P_MIN)) && (q.hi <= PW'(P_MAX)));
    assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(drive_period));
    assert_change_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_period) |-> drive_period_vld);
endmodule

// File: tb/sim_reso_sweep_tracker.sv
module sim_reso_sweep_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 16, DW = 8, DIV = 2, WINDOW = 4;
    localparam int P_MIN = 100, P_MAX = 260, CSTEP = 20, FSTEP = 4, MARGIN = 20;
    localparam int RUN_LEN = 300;
    localparam int NROUNDS = 9;
    localparam int NC = (P_MAX - P_MIN) / CSTEP + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic adc_intr_n = 1'b1;
    logic [DW-1:0] adc_data;
    logic adc_cs_n, adc_wr_n, adc_rd_n;
    logic [PW-1:0] drive_period;
    logic drive_period_vld, locked;

    int checks = 0, failures = 0;
    int res = 110;
    int rounds = 0;
    int exp_q[$];
    int got_q[$];
    int res_list[NROUNDS] = '{110, 105, 258, 20, 300, 180, 0, 0, 0};

    always #(CLK_PERIOD / 2) clk = ~clk;

    reso_sweep_tracker #(
        .PW(PW), .DW(DW), .DIV(DIV), .WINDOW(WINDOW), .P_MIN(P_MIN), .P_MAX(P_MAX),
        .COARSE_STEP(CSTEP), .FINE_STEP(FSTEP), .EDGE_MARGIN(MARGIN), .RUN_LEN(RUN_LEN)
    ) u0 (
        .clk, .rst_n, .adc_intr_n, .adc_data, .adc_cs_n, .adc_wr_n, .adc_rd_n,
        .drive_period, .drive_period_vld, .locked
    );

    function automatic int curve(int p, int r);
        int dd = (p > r) ? p - r : r - p;
        return (dd >= 60) ? 0 : 240 - 4 * dd;
    endfunction

    assign adc_data = DW'(curve(int'(drive_period), res));

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic void build_exp(int r);
        int best = P_MIN, mx = 0, c, s;
        exp_q.delete();
        for (int p = P_MIN; p <= P_MAX; p += CSTEP) begin
            exp_q.push_back(p);
            s = WINDOW * curve(p, r);
            if (s > mx) begin mx = s; best = p; end
        end
        c = (best < P_MIN + MARGIN) ? P_MIN + MARGIN :
            (best > P_MAX - MARGIN) ? P_MAX - MARGIN : best;
        best = c - MARGIN; mx = 0;
        for (int p = c - MARGIN; p <= c + MARGIN; p += FSTEP) begin
            exp_q.push_back(p);
            s = WINDOW * curve(p, r);
            if (s > mx) begin mx = s; best = p; end
        end
        exp_q.push_back(best);
    endfunction

    // ADC model: conversion done after a random delay, released when read starts
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge adc_wr_n);
            repeat ($urandom_range(1, 8)) @(negedge clk);
            adc_intr_n = 1'b0;
            @(negedge adc_rd_n);
            @(negedge clk);
            adc_intr_n = 1'b1;
        end
    end

    // Handshake monitor (R2)
    int hs_bad = 0, conv = 0, rd_w = 0, wr_w = 0;
    logic rd_prev = 1'b1, wr_prev = 1'b1, intr_prev = 1'b1;
    always @(negedge clk) if (rst_n) begin
        if ((!adc_wr_n && adc_cs_n) || (!adc_rd_n && adc_cs_n) || (!adc_rd_n && !adc_wr_n))
            hs_bad++;
        if (!adc_rd_n && rd_prev && intr_prev) hs_bad++;
        if (!adc_rd_n) rd_w++;
        if (!adc_wr_n) wr_w++;
        if (adc_rd_n && !rd_prev) begin
            conv++;
            if (rd_w != DIV) hs_bad++;
            rd_w = 0;
            if (!adc_cs_n) hs_bad++;
        end
        if (adc_wr_n && !wr_prev) begin
            if (wr_w != DIV) hs_bad++;
            wr_w = 0;
        end
        rd_prev = adc_rd_n; wr_prev = adc_wr_n; intr_prev = adc_intr_n;
    end

    // Sweep monitor (R3..R10)
    logic lk_prev = 1'b0;
    int run_len = 0;
    always @(negedge clk) if (rst_n && rounds < NROUNDS) begin
        if (drive_period_vld) got_q.push_back(int'(drive_period));
        if (locked && !lk_prev) begin
            check(got_q.size() == exp_q.size(), "R10 issued-count", got_q.size(), exp_q.size());
            if (got_q.size() == exp_q.size()) begin
                for (int i = 0; i < exp_q.size(); i++) begin
                    string tag;
                    if (i == 0)                     tag = "R9 restart";
                    else if (i < NC)                tag = "R5 coarse";
                    else if (i == NC)               tag = "R6 clamp";
                    else if (i < exp_q.size() - 1)  tag = "R7 fine";
                    else                            tag = "R4 R3 lock point";
                    check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
                end
            end
            check(int'(drive_period) == exp_q[exp_q.size() - 1], "R8 locked period",
                  int'(drive_period), exp_q[exp_q.size() - 1]);
            got_q.delete();
            run_len = 1;
            res = res_list[(rounds + 1) % NROUNDS];
            build_exp(res);
        end else if (locked) begin
            run_len++;
            if (drive_period_vld) check(0, "R8 change while locked", 1, 0);
        end
        if (!locked && lk_prev) begin
            check(run_len == RUN_LEN, "R8 run length", run_len, RUN_LEN);
            rounds++;
        end
        lk_prev = locked;
    end

    initial begin
        int cyc = 0;
        void'($urandom(32'd12345));
        for (int i = 6; i < NROUNDS; i++) res_list[i] = $urandom_range(60, 300);
        res = res_list[0];
        build_exp(res);
        repeat (3) @(negedge clk);
        check(adc_cs_n && adc_wr_n && adc_rd_n, "R1 pins idle in reset",
              {adc_cs_n, adc_wr_n, adc_rd_n}, 3'b111);
        check(!locked && !drive_period_vld, "R1 outputs quiet in reset",
              {locked, drive_period_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_period_vld && drive_period == PW'(P_MIN), "R1 first period",
              int'(drive_period), P_MIN);
        while (rounds < NROUNDS && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        check(rounds == NROUNDS, "watchdog", rounds, NROUNDS);
        check(hs_bad == 0, "R2 handshake violations", hs_bad, 0);
        check(conv > 0, "R2 conversions seen", conv, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule